// File: doc/BRIEF.md
# Serial Register Slave for Converter Trim and Configuration

This block is the register-side endpoint of a four-signal serial interface (chip select, serial clock, serial data in, serial data out) on a data converter. A host writes a 16-bit instruction word and then one or more data bytes. The block holds a port configuration byte, a burst stop address, two fixed identification bytes, a channel select byte and five trim registers. The trim registers drive the offset and gain adjustment inputs of the converter core.

All serial pins pass through synchronizers and are sampled by the block's own system clock. The serial clock must therefore run well below that clock (at least eight system cycles per serial half period). Incoming bits are taken on the serial clock's rising edge and outgoing bits change on its falling edge.

A transfer may carry a burst of bytes. The address steps by one after each byte. The burst ends when chip select is released, or when a byte at the programmed stop address completes. The bit order of every word and byte can be reversed by one configuration bit. That bit is mirrored in the configuration byte so that the byte reads the same in either order.

Top module: `spi_regmap_slave`

## Requirements
- R1: After reset the configuration register reads 0x18, the burst stop register reads 0x00, the channel select register reads 0x00, both offset trims output 0x80, medium and fine gain output 0x80, coarse gain outputs 0x0, and miso_oe is low.
- R2: Each transfer starts with a 16-bit instruction word: bit 15 is 1 for read and 0 for write, bits 14:13 are ignored, and bits 12:0 are the start address. Data bytes follow. Inputs are taken on the rising edge of sclk and miso changes on the falling edge. With the default bit order, the most significant bit goes first.
- R3: Within one transfer the address increases by one after each data byte, so consecutive bytes read or write consecutive registers.
- R4: Raising cs_n ends the transfer at once. A partly shifted byte is discarded, and the next low period of cs_n starts with a new instruction word.
- R5: When a data byte at the address held in the burst stop register (address 0x02) completes, the next 16 bits on the same chip select period are taken as a new instruction word.
- R6: When configuration bit 6 is set, the instruction word and all data bytes are shifted least significant bit first, in both directions.
- R7: The configuration register (address 0x00) reads as {sdo_on, lsb_first, 0, 1, 1, 0, lsb_first, sdo_on} from bit 7 down to bit 0. On write, bit 7 sets sdo_on and bit 6 sets lsb_first.
- R8: Writing the configuration register with bit 5 set returns every writable register to its reset value.
- R9: Address 0x08 reads the CHIP_ID parameter and address 0x09 reads the CHIP_REV parameter. Writes to them have no effect.
- R10: Trim registers live at 0x20 (coarse offset), 0x21 (fine offset), 0x22 (coarse gain), 0x23 (medium gain) and 0x24 (fine gain). While bit 0 of the channel select register (0x10) is clear, reads of these addresses return 0xAD and writes to them have no effect.
- R11: Coarse gain keeps only bits 3:0 of a written byte and reads back with bits 7:4 zero.
- R12: Reads of any unmapped address return 0x00, and writes to unmapped addresses change nothing.
- R13: miso_oe is high while read data is being shifted out or while sdo_on is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for miso pad |
| offset_coarse | output | 8 | Coarse offset trim |
| offset_fine | output | 8 | Fine offset trim |
| gain_coarse | output | 4 | Coarse gain trim |
| gain_medium | output | 8 | Medium gain trim |
| gain_fine | output | 8 | Fine gain trim |

## Verification
A bad bit counter or a stale shift register corrupts the next byte. That shows up either as a wrong trim value on the ports at the end of the same transfer, or as a wrong read-back within 24 serial clocks. An address that fails to step, or a burst stop that is missed, puts data into the neighbouring trim register. That error is visible on the trim outputs as soon as chip select rises. Faults in the channel-select gating or in the bit-order state persist. They appear on the next read of a trim register as a wrong value or a bit-reversed value, or as 0xAD where real data was expected.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INSTR,
    PH_DATA
  } phase_e;

  localparam int unsigned A_CFG    = 0;
  localparam int unsigned A_BEND   = 2;
  localparam int unsigned A_ID     = 8;
  localparam int unsigned A_REV    = 9;
  localparam int unsigned A_INDEX  = 16;
  localparam int unsigned A_TRIM0  = 32;
  localparam int unsigned NUM_TRIM = 5;
  localparam int unsigned GC_SLOT  = 2;

  localparam int unsigned CFG_SDO_BIT  = 7;
  localparam int unsigned CFG_LSB_BIT  = 6;
  localparam int unsigned CFG_SRST_BIT = 5;

  localparam logic [7:0] TRIM_MID = 8'h80;
  localparam logic [7:0] IDX_ERR  = 8'hAD;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);

  localparam int unsigned NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b001;

  logic [STAGES-1:0][NPIN-1:0] stage_q;
  logic [NPIN-1:0]             pin_in;
  logic [NPIN-1:0]             pin_s;
  logic                        sclk_prev_q;

  assign pin_in = {mosi_i, sclk_i, cs_n_i};
  assign pin_s  = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= {STAGES{PIN_RST}};
      sclk_prev_q <= 1'b0;
    end else begin
      stage_q     <= {stage_q[STAGES-2:0], pin_in};
      sclk_prev_q <= pin_s[1];
    end
  end

  assign cs_n_s    = pin_s[0];
  assign mosi_s    = pin_s[2];
  assign sclk_rise = pin_s[1] & ~sclk_prev_q;
  assign sclk_fall = ~pin_s[1] & sclk_prev_q;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_regmap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned INSTR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              lsb_first,
  input  logic              sdo_on,
  input  logic [DATA_W-1:0] burst_end,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);

  localparam int unsigned CNT_W = $clog2(INSTR_W);

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [INSTR_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0]  tx_q, tx_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               rw_q, rw_d;
  logic               miso_q, miso_d;
  logic               byte_done, hit_end;

  assign hit_end = (addr_q == ADDR_W'(burst_end));

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    addr_d    = addr_q;
    rw_d      = rw_q;
    miso_d    = miso_q;
    byte_done = 1'b0;
    wr_en     = 1'b0;
    wr_data   = lsb_first ? rx_d[INSTR_W-1 -: DATA_W] : rx_d[DATA_W-1:0];
    if (cs_n_s) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (phase_q == PH_IDLE) begin
      phase_d = PH_INSTR;
      cnt_d   = '0;
    end else begin
      if (sclk_rise) begin
        rx_d = lsb_first ? {mosi_s, rx_q[INSTR_W-1:1]} : {rx_q[INSTR_W-2:0], mosi_s};
        wr_data = lsb_first ? rx_d[INSTR_W-1 -: DATA_W] : rx_d[DATA_W-1:0];
        cnt_d = cnt_q + 1'b1;
        if (phase_q == PH_INSTR && cnt_q == CNT_W'(INSTR_W-1)) begin
          rw_d    = rx_d[INSTR_W-1];
          addr_d  = rx_d[ADDR_W-1:0];
          phase_d = PH_DATA;
          cnt_d   = '0;
        end else if (phase_q == PH_DATA && cnt_q == CNT_W'(DATA_W-1)) begin
          byte_done = 1'b1;
          wr_en     = ~rw_q;
          cnt_d     = '0;
          if (hit_end) phase_d = PH_INSTR;
          else         addr_d  = addr_q + 1'b1;
        end
      end
      if (sclk_fall && phase_q == PH_DATA) begin
        if (cnt_q == '0) begin
          miso_d = lsb_first ? rd_data[0] : rd_data[DATA_W-1];
          tx_d   = lsb_first ? (rd_data >> 1) : (rd_data << 1);
        end else begin
          miso_d = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
          tx_d   = lsb_first ? (tx_q >> 1) : (tx_q << 1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (sclk_rise) rx_q <= rx_d;
      if (sclk_fall) tx_q <= tx_d;
      if (sclk_fall) miso_q <= miso_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
    end
  end

  assign addr    = addr_q;
  assign miso    = miso_q;
  assign miso_oe = sdo_on | (phase_q == PH_DATA && rw_q && !cs_n_s);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !hit_end && !cs_n_s |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  // R5
  burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && hit_end && !cs_n_s |=> phase_q == PH_INSTR && cnt_q == '0);

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_s) |=> phase_q == PH_IDLE);

  // R2
  data_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_DATA |-> cnt_q < CNT_W'(DATA_W));

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_regmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned GAIN_C_W  = 4,
  parameter logic [7:0]  CHIP_ID   = 8'h5C,
  parameter logic [7:0]  CHIP_REV  = 8'h03
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                sdo_on,
  output logic                lsb_first,
  output logic [DATA_W-1:0]   burst_end,
  output logic [DATA_W-1:0]   offset_coarse,
  output logic [DATA_W-1:0]   offset_fine,
  output logic [GAIN_C_W-1:0] gain_coarse,
  output logic [DATA_W-1:0]   gain_medium,
  output logic [DATA_W-1:0]   gain_fine
);

  localparam logic [DATA_W-1:0] GC_MASK = DATA_W'((1 << GAIN_C_W) - 1);

  function automatic logic [DATA_W-1:0] trim_rst(input int unsigned i);
    return (i == GC_SLOT) ? '0 : DATA_W'(TRIM_MID);
  endfunction

  function automatic logic [DATA_W-1:0] trim_mask(input int unsigned i);
    return (i == GC_SLOT) ? GC_MASK : '1;
  endfunction

  logic                             sdo_q, sdo_d, lsb_q, lsb_d;
  logic [DATA_W-1:0]                bend_q, bend_d, idx_q, idx_d;
  logic [NUM_TRIM-1:0][DATA_W-1:0]  trim_q, trim_d;
  logic                             soft_rst;

  assign soft_rst = wr_en && wr_addr == ADDR_W'(A_CFG) && wr_data[CFG_SRST_BIT];

  always_comb begin
    sdo_d  = sdo_q;
    lsb_d  = lsb_q;
    bend_d = bend_q;
    idx_d  = idx_q;
    trim_d = trim_q;
    if (soft_rst) begin
      sdo_d  = 1'b0;
      lsb_d  = 1'b0;
      bend_d = '0;
      idx_d  = '0;
      for (int unsigned i = 0; i < NUM_TRIM; i++) trim_d[i] = trim_rst(i);
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CFG)) begin
        sdo_d = wr_data[CFG_SDO_BIT];
        lsb_d = wr_data[CFG_LSB_BIT];
      end
      if (wr_addr == ADDR_W'(A_BEND))  bend_d = wr_data;
      if (wr_addr == ADDR_W'(A_INDEX)) idx_d  = wr_data;
      for (int unsigned i = 0; i < NUM_TRIM; i++)
        if (wr_addr == ADDR_W'(A_TRIM0 + i) && idx_q[0]) trim_d[i] = wr_data & trim_mask(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q  <= 1'b0;
      lsb_q  <= 1'b0;
      bend_q <= '0;
      idx_q  <= '0;
      for (int unsigned i = 0; i < NUM_TRIM; i++) trim_q[i] <= trim_rst(i);
    end else if (wr_en) begin
      sdo_q  <= sdo_d;
      lsb_q  <= lsb_d;
      bend_q <= bend_d;
      idx_q  <= idx_d;
      trim_q <= trim_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CFG))
      rd_data = {sdo_q, lsb_q, 1'b0, 1'b1, 1'b1, 1'b0, lsb_q, sdo_q};
    if (rd_addr == ADDR_W'(A_BEND))  rd_data = bend_q;
    if (rd_addr == ADDR_W'(A_ID))    rd_data = CHIP_ID;
    if (rd_addr == ADDR_W'(A_REV))   rd_data = CHIP_REV;
    if (rd_addr == ADDR_W'(A_INDEX)) rd_data = idx_q;
    for (int unsigned i = 0; i < NUM_TRIM; i++)
      if (rd_addr == ADDR_W'(A_TRIM0 + i)) rd_data = idx_q[0] ? trim_q[i] : IDX_ERR;
  end

  assign sdo_on        = sdo_q;
  assign lsb_first     = lsb_q;
  assign burst_end     = bend_q;
  assign offset_coarse = trim_q[0];
  assign offset_fine   = trim_q[1];
  assign gain_coarse   = trim_q[GC_SLOT][GAIN_C_W-1:0];
  assign gain_medium   = trim_q[3];
  assign gain_fine     = trim_q[4];

  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> trim_q[0] == TRIM_MID && idx_q == '0 && !lsb_q);

  // R10
  idx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !idx_q[0] && wr_addr != ADDR_W'(A_CFG) |=> $stable(trim_q));

  // R11
  gc_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trim_q[GC_SLOT][DATA_W-1:GAIN_C_W] == '0);

endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave
  import spi_regmap_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned INSTR_W     = 16,
  parameter int unsigned GAIN_C_W    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  CHIP_ID     = 8'h5C,
  parameter logic [7:0]  CHIP_REV    = 8'h03
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                mosi,
  output logic                miso,
  output logic                miso_oe,
  output logic [DATA_W-1:0]   offset_coarse,
  output logic [DATA_W-1:0]   offset_fine,
  output logic [GAIN_C_W-1:0] gain_coarse,
  output logic [DATA_W-1:0]   gain_medium,
  output logic [DATA_W-1:0]   gain_fine
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cs_n_s, mosi_s, sclk_rise, sclk_fall;
  logic              lsb_first, sdo_on, wr_en;
  logic [DATA_W-1:0] burst_end, rd_data, wr_data;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_int_n),
    .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  spi_shift_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INSTR_W(INSTR_W)) eng_i (
    .clk(clk), .rst_n(rst_int_n),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .lsb_first(lsb_first), .sdo_on(sdo_on), .burst_end(burst_end), .rd_data(rd_data),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .miso(miso), .miso_oe(miso_oe)
  );

  spi_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_C_W(GAIN_C_W),
    .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)
  ) regs_i (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data),
    .sdo_on(sdo_on), .lsb_first(lsb_first), .burst_end(burst_end),
    .offset_coarse(offset_coarse), .offset_fine(offset_fine), .gain_coarse(gain_coarse),
    .gain_medium(gain_medium), .gain_fine(gain_fine)
  );

endmodule

// File: tb/spi_regmap_slave_tb.sv
module spi_regmap_slave_tb_top;

  localparam int HALF = 8;
  localparam logic [7:0] ID_V = 8'h5C, REV_V = 8'h03;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic [7:0] off_c, off_f, g_m, g_f;
  logic [3:0] g_c;

  int n_run = 0, n_fail = 0;
  logic oe_all, oe_any;

  logic m_sdo, m_lsb;
  logic [7:0] m_bend, m_idx, m_oc, m_of, m_gm, m_gf;
  logic [3:0] m_gc;

  always #2 clk = ~clk;

  spi_regmap_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe),
    .offset_coarse(off_c), .offset_fine(off_f), .gain_coarse(g_c),
    .gain_medium(g_m), .gain_fine(g_f)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic mdl_reset();
    m_sdo = 0; m_lsb = 0; m_bend = 0; m_idx = 0;
    m_oc = 8'h80; m_of = 8'h80; m_gm = 8'h80; m_gf = 8'h80; m_gc = 0;
  endtask

  task automatic mdl_wr(input logic [12:0] a, input logic [7:0] d);
    if (a == 13'h00) begin
      if (d[5]) mdl_reset();
      else begin m_sdo = d[7]; m_lsb = d[6]; end
    end else if (a == 13'h02) m_bend = d;
    else if (a == 13'h10) m_idx = d;
    else if (m_idx[0]) begin
      case (a)
        13'h20: m_oc = d;
        13'h21: m_of = d;
        13'h22: m_gc = d[3:0];
        13'h23: m_gm = d;
        13'h24: m_gf = d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [12:0] a);
    case (a)
      13'h00: return {m_sdo, m_lsb, 4'b0110, m_lsb, m_sdo};
      13'h02: return m_bend;
      13'h08: return ID_V;
      13'h09: return REV_V;
      13'h10: return m_idx;
      13'h20: return m_idx[0] ? m_oc : 8'hAD;
      13'h21: return m_idx[0] ? m_of : 8'hAD;
      13'h22: return m_idx[0] ? {4'h0, m_gc} : 8'hAD;
      13'h23: return m_idx[0] ? m_gm : 8'hAD;
      13'h24: return m_idx[0] ? m_gf : 8'hAD;
      default: return 8'h00;
    endcase
  endfunction

  task automatic bit_x(input logic b, output logic r, input logic track);
    @(negedge clk); mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso;
    if (track) begin oe_all &= miso_oe; oe_any |= miso_oe; end
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic word_x(input logic rd, input logic [12:0] a);
    logic [15:0] w;
    logic r;
    w = {rd, 2'b00, a};
    for (int i = 0; i < 16; i++) bit_x(m_lsb ? w[i] : w[15-i], r, 1'b0);
  endtask

  task automatic byte_x(input logic [7:0] dout, output logic [7:0] din);
    logic r;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit_x(m_lsb ? dout[i] : dout[7-i], r, 1'b1);
      if (m_lsb) din[i] = r; else din[7-i] = r;
    end
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    cs_lo(); word_x(1'b0, a); byte_x(d, dummy); cs_hi();
    mdl_wr(a, d);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    cs_lo(); word_x(1'b1, a); byte_x(8'h00, d); cs_hi();
  endtask

  task automatic chk_rd(input string req, input logic [12:0] a);
    logic [7:0] d;
    rd1(a, d);
    check(req, {8'h0, d}, {8'h0, exp_rd(a)});
  endtask

  task automatic chk_ports(input string req);
    check(req, {off_c, off_f}, {m_oc, m_of});
    check(req, {4'h0, g_c, g_m}, {4'h0, m_gc, m_gm});
    check(req, {8'h0, g_f}, {8'h0, m_gf});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic [12:0] pool [12];
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    pool = '{13'h02, 13'h08, 13'h09, 13'h10, 13'h10, 13'h20, 13'h21, 13'h22,
             13'h23, 13'h24, 13'h05, 13'h1FFF};
    mdl_reset();
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state at ports and through reads
    chk_ports("R1");
    check("R1 oe", {15'h0, miso_oe}, 16'h0);
    chk_rd("R1 cfg", 13'h00);
    chk_rd("R1 bend", 13'h02);
    chk_rd("R1 index", 13'h10);

    // R10 gated: read error byte, write ignored
    chk_rd("R10 read gated", 13'h20);
    wr1(13'h20, 8'h33);
    check("R10 write gated", {8'h0, off_c}, 16'h0080);
    chk_rd("R10 still gated", 13'h21);

    // R2 single write/read, R13 oe during read and not during write
    wr1(13'h10, 8'h01);
    wr1(13'h21, 8'hA5);
    check("R13 oe off in write", {15'h0, oe_any}, 16'h0);
    check("R2 write port", {8'h0, off_f}, 16'h00A5);
    rd1(13'h21, d);
    check("R2 read", {8'h0, d}, 16'h00A5);
    check("R13 oe on in read", {15'h0, oe_all}, 16'h1);

    // R3 burst write then burst read
    cs_lo(); word_x(1'b0, 13'h20);
    byte_x(8'h11, d); byte_x(8'h22, d); byte_x(8'h3C, d); byte_x(8'h44, d); byte_x(8'h55, d);
    cs_hi();
    mdl_wr(13'h20, 8'h11); mdl_wr(13'h21, 8'h22); mdl_wr(13'h22, 8'h3C);
    mdl_wr(13'h23, 8'h44); mdl_wr(13'h24, 8'h55);
    chk_ports("R3 burst write");
    cs_lo(); word_x(1'b1, 13'h22);
    byte_x(8'h00, d); byte_x(8'h00, d2);
    cs_hi();
    check("R3 burst read", {d, d2}, {exp_rd(13'h22), exp_rd(13'h23)});

    // R11 coarse gain width
    wr1(13'h22, 8'hF7);
    check("R11 port", {12'h0, g_c}, 16'h0007);
    chk_rd("R11 read", 13'h22);

    // R4 cs released mid byte
    cs_lo(); word_x(1'b0, 13'h24);
    for (int i = 0; i < 4; i++) begin logic r; bit_x(1'b1, r, 1'b0); end
    cs_hi();
    check("R4 partial dropped", {8'h0, g_f}, {8'h0, m_gf});
    chk_rd("R4 fresh instr", 13'h24);

    // R5 burst stop address
    wr1(13'h02, 8'h21);
    cs_lo(); word_x(1'b0, 13'h20);
    byte_x(8'h9A, d); byte_x(8'h6B, d);
    mdl_wr(13'h20, 8'h9A); mdl_wr(13'h21, 8'h6B);
    word_x(1'b1, 13'h23); byte_x(8'h00, d);
    cs_hi();
    check("R5 new instr read", {8'h0, d}, {8'h0, m_gm});
    chk_ports("R5 no spill");
    wr1(13'h02, 8'h00);

    // R9 id registers
    chk_rd("R9 id", 13'h08);
    chk_rd("R9 rev", 13'h09);
    wr1(13'h08, 8'hFF);
    chk_rd("R9 id ro", 13'h08);

    // R12 unmapped
    wr1(13'h05, 8'h77);
    chk_rd("R12 unmapped", 13'h05);
    chk_rd("R12 top addr", 13'h1FFF);
    chk_ports("R12 no effect");

    // R6 LSB first, R7 mirror readback
    wr1(13'h00, 8'h42);
    chk_rd("R7 cfg lsb", 13'h00);
    wr1(13'h23, 8'h01);
    check("R6 lsb write", {8'h0, g_m}, 16'h0001);
    wr1(13'h24, 8'hC5);
    check("R6 lsb write2", {8'h0, g_f}, 16'h00C5);
    chk_rd("R6 lsb read", 13'h24);
    wr1(13'h00, 8'h18);
    chk_rd("R6 back to msb", 13'h23);

    // R13 and R7 sdo_on
    wr1(13'h00, 8'h81);
    check("R13 oe idle sdo", {15'h0, miso_oe}, 16'h1);
    chk_rd("R7 cfg sdo", 13'h00);
    wr1(13'h00, 8'h18);
    check("R13 oe idle off", {15'h0, miso_oe}, 16'h0);

    // R8 soft reset
    wr1(13'h02, 8'h44);
    wr1(13'h00, 8'h24);
    chk_ports("R8 soft reset ports");
    chk_rd("R8 index", 13'h10);
    chk_rd("R8 bend", 13'h02);
    chk_rd("R8 cfg", 13'h00);

    // random single-byte traffic: R2 R10 R12
    for (int n = 0; n < 110; n++) begin
      logic [12:0] a;
      a = pool[$urandom % 12];
      if ($urandom % 2) begin
        wr1(a, 8'($urandom));
        chk_ports("R10 random write");
      end else begin
        chk_rd("R2 random read", a);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule